// File: doc/BRIEF.md
# Address Monitor Arm-and-Trigger Unit

This unit sits in a processor core. It implements the hardware side of an instruction that arms an address monitor. An arm request carries the following:

- an effective address;
- an extensions word;
- a hints word;
- the current privilege level;
- the operating mode;
- a feature-enable flag.

The unit checks the request against a fixed-priority fault ladder. A request with no fault latches the line-aligned address as the monitored range and sets the unit to the armed state. A faulting request reports a fault code and leaves the unit's state as it was.

While armed, the unit watches committed stores. A store to write-back memory whose line matches the monitored range sets a sticky triggered flag. A companion wait unit reads the armed and triggered flags. It drops the monitor back to idle with a one-cycle consume pulse.

Top module: `addr_monitor_unit`

## Requirements
- R1: A non-faulting arm latches the address, aligned down to LINE_BYTES (default 64), as `mon_base_o`. The same update sets `armed_o` and reports fault code 0.
- R2: While armed, a store with memory type write-back whose aligned address equals the base sets `triggered_o`. The flag stays set until a consume or a new successful arm. A store while idle has no effect.
- R3: Only memory type 3'd6 (write-back) can fire the trigger. A store of any other type is ignored, even when its address matches.
- R4: A nonzero extensions word gives fault code 2 (general protection). The arm is not performed.
- R5: The hints word has no effect on faults, arming or triggering.
- R6: With the feature flag clear, every request gives fault code 1 (invalid opcode), whatever the mode.
- R7: The mode encoding is 0 real, 1 protected, 2 virtual-8086 and 3 64-bit. Mode 2 always gives code 1. Modes 1 and 3 give code 1 when the privilege level is not 0. Mode 0 does not check privilege.
- R8: General protection (code 2) is raised in two address cases. In mode 3, the address is not canonical: bits [63:47] are not all equal. In mode 0, the address is above 0xFFFF.
- R9: Invalid-opcode causes take priority over general-protection causes. Each request reports exactly one code, and code 3 never appears.
- R10: A successful arm replaces any earlier range and clears `triggered_o`. A faulting arm leaves the base, armed and triggered flags unchanged.
- R11: A `consume_i` pulse returns the unit to idle, clearing both armed and triggered. If a successful arm arrives in the same cycle, the arm wins.
- R12: A store presented in the same cycle as a successful arm does not count against the new range.
- R13: `arm_resp_valid_o` and `arm_fault_o` follow an arm request by exactly one clock. All state outputs update one clock after their cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_valid_i | input | 1 | Arm request strobe |
| arm_addr_i | input | ADDR_W | Effective address to monitor |
| arm_ext_i | input | EXT_W | Extensions word, must be zero |
| arm_hint_i | input | HINT_W | Hints word, ignored |
| arm_cpl_i | input | 2 | Current privilege level |
| arm_mode_i | input | 2 | Operating mode |
| feat_en_i | input | 1 | Feature enable |
| arm_resp_valid_o | output | 1 | Arm response valid |
| arm_fault_o | output | 2 | Fault code: 0 none, 1 invalid opcode, 2 general protection |
| st_valid_i | input | 1 | Committed store strobe |
| st_addr_i | input | ADDR_W | Store address |
| st_memtype_i | input | 3 | Store memory type |
| consume_i | input | 1 | Wait-side consume pulse |
| armed_o | output | 1 | Monitor armed |
| triggered_o | output | 1 | Monitor triggered |
| mon_base_o | output | ADDR_W | Latched aligned base |

## Verification
Every result of this unit is due exactly one rising edge after the inputs that cause it. This holds for the arm response and fault code, the armed flag and base, and the triggered flag after a store or consume. The bench drives inputs on the falling edge and lets the next rising edge capture them. It compares all outputs at the falling edge that follows, against a bench model updated once per step. Same-cycle collisions are applied in one step and judged by the same one-cycle rule: arm with store, and arm with consume.

// File: rtl/amon_pkg.sv
package amon_pkg;
  typedef enum logic [1:0] {
    MODE_REAL = 2'd0,
    MODE_PROT = 2'd1,
    MODE_V86  = 2'd2,
    MODE_LONG = 2'd3
  } cpu_mode_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_UD   = 2'd1,
    FLT_GP   = 2'd2
  } fault_e;

  localparam logic [2:0] MT_WB = 3'd6;
endpackage

// File: rtl/amon_fault_check.sv
module amon_fault_check
  import amon_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int VA_W   = 48,
  parameter int EXT_W  = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [EXT_W-1:0]  ext_i,
  input  logic [1:0]        cpl_i,
  input  cpu_mode_e         mode_i,
  input  logic              feat_en_i,
  output fault_e            fault_o
);
  logic canon;
  logic real_ovf;

  generate
    if (VA_W >= ADDR_W) begin : g_canon_all
      assign canon = 1'b1;
    end else begin : g_canon_chk
      localparam int HI_W = ADDR_W - VA_W + 1;
      logic [HI_W-1:0] hi;
      assign hi    = addr_i[ADDR_W-1:VA_W-1];
      assign canon = (hi == '0) || (hi == '1);
    end
    if (ADDR_W > 16) begin : g_real_chk
      assign real_ovf = |addr_i[ADDR_W-1:16];
    end else begin : g_real_none
      assign real_ovf = 1'b0;
    end
  endgenerate

  logic ud_mode;
  logic gp_addr;

  always_comb begin
    ud_mode = 1'b0;
    gp_addr = 1'b0;
    unique case (mode_i)
      MODE_V86:  ud_mode = 1'b1;
      MODE_PROT: ud_mode = (cpl_i != 2'd0);
      MODE_LONG: begin
        ud_mode = (cpl_i != 2'd0);
        gp_addr = !canon;
      end
      default:   gp_addr = real_ovf;
    endcase
  end

  // invalid-opcode outranks general-protection
  always_comb begin
    if (!feat_en_i)           fault_o = FLT_UD;
    else if (ud_mode)         fault_o = FLT_UD;
    else if (ext_i != '0)     fault_o = FLT_GP;
    else if (gp_addr)         fault_o = FLT_GP;
    else                      fault_o = FLT_NONE;
  end
endmodule

// File: rtl/amon_align.sv
module amon_align #(
  parameter int ADDR_W = 64,
  parameter int OFF_W  = 6
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] line_o
);
  assign line_o = {addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  logic unused_off;
  assign unused_off = ^addr_i[OFF_W-1:0];
endmodule

// File: rtl/amon_state.sv
module amon_state
  import amon_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_valid_i,
  input  fault_e            fault_i,
  input  logic [ADDR_W-1:0] arm_line_i,
  input  logic              st_valid_i,
  input  logic [ADDR_W-1:0] st_line_i,
  input  logic [2:0]        st_type_i,
  input  logic              consume_i,
  output logic              resp_valid_o,
  output fault_e            fault_o,
  output logic              armed_o,
  output logic              trig_o,
  output logic [ADDR_W-1:0] base_o
);
  logic arm_ok;
  logic st_hit;

  assign arm_ok = arm_valid_i && (fault_i == FLT_NONE);
  assign st_hit = armed_o && st_valid_i && (st_type_i == MT_WB) && (st_line_i == base_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o <= 1'b0;
      fault_o      <= FLT_NONE;
      armed_o      <= 1'b0;
      trig_o       <= 1'b0;
      base_o       <= '0;
    end else begin
      resp_valid_o <= arm_valid_i;
      if (arm_valid_i) fault_o <= fault_i;
      // new arm wins over consume and masks a same-cycle store
      if (arm_ok) begin
        base_o  <= arm_line_i;
        armed_o <= 1'b1;
        trig_o  <= 1'b0;
      end else if (consume_i) begin
        armed_o <= 1'b0;
        trig_o  <= 1'b0;
      end else if (st_hit) begin
        trig_o  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/addr_monitor_unit.sv
module addr_monitor_unit
  import amon_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int VA_W       = 48,
  parameter int EXT_W      = 32,
  parameter int HINT_W     = 32,
  parameter int LINE_BYTES = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_valid_i,
  input  logic [ADDR_W-1:0] arm_addr_i,
  input  logic [EXT_W-1:0]  arm_ext_i,
  input  logic [HINT_W-1:0] arm_hint_i,
  input  logic [1:0]        arm_cpl_i,
  input  logic [1:0]        arm_mode_i,
  input  logic              feat_en_i,
  output logic              arm_resp_valid_o,
  output logic [1:0]        arm_fault_o,
  input  logic              st_valid_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic [2:0]        st_memtype_i,
  input  logic              consume_i,
  output logic              armed_o,
  output logic              triggered_o,
  output logic [ADDR_W-1:0] mon_base_o
);
  localparam int OFF_W = $clog2(LINE_BYTES);

  fault_e            fault_c;
  fault_e            fault_q;
  logic [ADDR_W-1:0] arm_line;
  logic [ADDR_W-1:0] st_line;

  logic unused_hint;
  assign unused_hint = ^arm_hint_i;

  amon_fault_check #(.ADDR_W(ADDR_W), .VA_W(VA_W), .EXT_W(EXT_W)) u_fault (
    .addr_i    (arm_addr_i),
    .ext_i     (arm_ext_i),
    .cpl_i     (arm_cpl_i),
    .mode_i    (cpu_mode_e'(arm_mode_i)),
    .feat_en_i (feat_en_i),
    .fault_o   (fault_c)
  );

  amon_align #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_arm_align (
    .addr_i (arm_addr_i),
    .line_o (arm_line)
  );

  amon_align #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_st_align (
    .addr_i (st_addr_i),
    .line_o (st_line)
  );

  amon_state #(.ADDR_W(ADDR_W)) u_state (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .arm_valid_i  (arm_valid_i),
    .fault_i      (fault_c),
    .arm_line_i   (arm_line),
    .st_valid_i   (st_valid_i),
    .st_line_i    (st_line),
    .st_type_i    (st_memtype_i),
    .consume_i    (consume_i),
    .resp_valid_o (arm_resp_valid_o),
    .fault_o      (fault_q),
    .armed_o      (armed_o),
    .trig_o       (triggered_o),
    .base_o       (mon_base_o)
  );

  assign arm_fault_o = fault_q;
endmodule

// File: rtl/amon_checker.sv
module amon_checker
  import amon_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              arm_valid_i,
  input logic [1:0]        arm_mode_i,
  input logic              feat_en_i,
  input logic              st_valid_i,
  input logic [2:0]        st_memtype_i,
  input logic              consume_i,
  input logic              arm_resp_valid_o,
  input logic [1:0]        arm_fault_o,
  input logic              armed_o,
  input logic              triggered_o,
  input logic [ADDR_W-1:0] mon_base_o
);
  // R13
  a_r13_resp_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_valid_i |=> arm_resp_valid_o);

  // R2
  a_r2_trig_needs_armed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    triggered_o |-> armed_o);

  // R3
  a_r3_nonwb_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!triggered_o && !arm_valid_i && st_valid_i && st_memtype_i != MT_WB) |=> !triggered_o);

  // R10
  a_r10_base_only_on_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_valid_i |=> $stable(mon_base_o));

  // R6
  a_r6_feat_off_ud: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_valid_i && !feat_en_i) |=> (arm_fault_o == FLT_UD));

  // R7
  a_r7_v86_ud: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_valid_i && arm_mode_i == MODE_V86) |=> (arm_fault_o == FLT_UD));

  // R9
  a_r9_code_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_fault_o != 2'd3);

  // R11
  a_r11_consume_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (consume_i && !arm_valid_i) |=> (!armed_o && !triggered_o));
endmodule

bind addr_monitor_unit amon_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .arm_valid_i      (arm_valid_i),
  .arm_mode_i       (arm_mode_i),
  .feat_en_i        (feat_en_i),
  .st_valid_i       (st_valid_i),
  .st_memtype_i     (st_memtype_i),
  .consume_i        (consume_i),
  .arm_resp_valid_o (arm_resp_valid_o),
  .arm_fault_o      (arm_fault_o),
  .armed_o          (armed_o),
  .triggered_o      (triggered_o),
  .mon_base_o       (mon_base_o)
);

// File: tb/sim_addr_monitor_unit.sv
`timescale 1ns/1ps
module sim_addr_monitor_unit;
  localparam logic [2:0] WB = 3'd6;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        arm_valid_i = 1'b0;
  logic [63:0] arm_addr_i = '0;
  logic [31:0] arm_ext_i = '0;
  logic [31:0] arm_hint_i = '0;
  logic [1:0]  arm_cpl_i = '0;
  logic [1:0]  arm_mode_i = '0;
  logic        feat_en_i = 1'b0;
  logic        arm_resp_valid_o;
  logic [1:0]  arm_fault_o;
  logic        st_valid_i = 1'b0;
  logic [63:0] st_addr_i = '0;
  logic [2:0]  st_memtype_i = '0;
  logic        consume_i = 1'b0;
  logic        armed_o;
  logic        triggered_o;
  logic [63:0] mon_base_o;

  always #2 clk_i = ~clk_i;

  addr_monitor_unit u0 (.*);

  int n_chk = 0;
  int n_fail = 0;
  logic        m_armed = 0;
  logic        m_trig = 0;
  logic [63:0] m_base = '0;

  function automatic logic [1:0] exp_fault(logic [63:0] a, logic [31:0] e,
                                           logic [1:0] cpl, logic [1:0] md, logic fe);
    if (!fe) return 2'd1;
    if (md == 2'd2) return 2'd1;
    if ((md == 2'd1 || md == 2'd3) && cpl != 0) return 2'd1;
    if (e != 0) return 2'd2;
    if (md == 2'd3 && !(a[63:47] == '0 || a[63:47] == '1)) return 2'd2;
    if (md == 2'd0 && a > 64'hFFFF) return 2'd2;
    return 2'd0;
  endfunction

  function automatic logic [63:0] line_of(logic [63:0] a);
    return {a[63:6], 6'd0};
  endfunction

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, logic av, logic [63:0] a, logic [31:0] e,
                      logic [31:0] h, logic [1:0] cpl, logic [1:0] md, logic fe,
                      logic sv, logic [63:0] sa, logic [2:0] st, logic cn);
    logic [1:0] f;
    arm_valid_i = av; arm_addr_i = a; arm_ext_i = e; arm_hint_i = h;
    arm_cpl_i = cpl; arm_mode_i = md; feat_en_i = fe;
    st_valid_i = sv; st_addr_i = sa; st_memtype_i = st; consume_i = cn;
    @(posedge clk_i);
    @(negedge clk_i);
    arm_valid_i = 0; st_valid_i = 0; consume_i = 0;
    f = av ? exp_fault(a, e, cpl, md, fe) : 2'd0;
    if (av && f == 0) begin
      m_base = line_of(a); m_armed = 1; m_trig = 0;
    end else if (cn) begin
      m_armed = 0; m_trig = 0;
    end else if (m_armed && sv && st == WB && line_of(sa) == m_base) begin
      m_trig = 1;
    end
    chk(tag, "resp_valid", 64'(arm_resp_valid_o), 64'(av));
    if (av) chk(tag, "fault", 64'(arm_fault_o), 64'(f));
    chk(tag, "armed", 64'(armed_o), 64'(m_armed));
    chk(tag, "triggered", 64'(triggered_o), 64'(m_trig));
    chk(tag, "base", mon_base_o, m_base);
  endtask

  task automatic arm(string tag, logic [63:0] a, logic [31:0] e, logic [31:0] h,
                     logic [1:0] cpl, logic [1:0] md, logic fe);
    step(tag, 1, a, e, h, cpl, md, fe, 0, '0, 3'd0, 0);
  endtask

  task automatic store(string tag, logic [63:0] sa, logic [2:0] st);
    step(tag, 0, '0, '0, '0, 0, 0, 1, 1, sa, st, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk_i);
    chk("R1", "reset armed", 64'(armed_o), 0);
    chk("R1", "reset triggered", 64'(triggered_o), 0);
    chk("R13", "reset resp", 64'(arm_resp_valid_o), 0);
    chk("R1", "reset base", mon_base_o, 0);
    rst_ni = 1;
    @(negedge clk_i);

    store("R2", 64'h1000, WB);
    arm("R1", 64'h1234_5678, 0, 0, 0, 1, 1);
    chk("R1", "aligned base", mon_base_o, 64'h1234_5640);
    store("R3", 64'h1234_5640, 3'd0);
    store("R3", 64'h1234_5650, 3'd4);
    store("R2", 64'h1234_5680, WB);
    store("R2", 64'h1234_567F, WB);
    store("R2", 64'h9999_0000, WB);
    arm("R4", 64'h2000, 32'h1, 0, 0, 1, 1);
    arm("R10", 64'h3000, 32'h8000_0000, 0, 0, 3, 1);
    step("R11", 0, '0, '0, '0, 0, 0, 1, 0, '0, 3'd0, 1);
    arm("R5", 64'hFFC0, 0, 32'hFFFF_FFFF, 0, 0, 1);
    store("R5", 64'hFFE3, WB);
    arm("R8", 64'h1_0000, 0, 0, 0, 0, 1);
    arm("R8", 64'h0000_8000_0000_0000, 0, 0, 0, 3, 1);
    arm("R8", 64'hFFFF_8000_0000_0040, 0, 0, 0, 3, 1);
    arm("R6", 64'h40, 0, 0, 0, 0, 0);
    arm("R6", 64'h40, 32'h3, 0, 0, 3, 0);
    arm("R7", 64'h40, 0, 0, 0, 2, 1);
    arm("R7", 64'h40, 0, 0, 3, 1, 1);
    arm("R7", 64'h80, 0, 0, 3, 0, 1);
    arm("R9", 64'h0000_9000_0000_0000, 32'h7, 0, 1, 3, 1);
    step("R12", 1, 64'h5000, 0, 0, 0, 1, 1, 1, 64'h5010, WB, 0);
    store("R12", 64'h5020, WB);
    arm("R10", 64'h6000, 0, 0, 0, 1, 1);
    step("R11", 1, 64'h7000, 0, 0, 0, 1, 1, 0, '0, 3'd0, 1);

    for (int i = 0; i < 600; i++) begin
      int op = $urandom % 8;
      if (op < 3) begin
        logic [1:0]  md = 2'($urandom);
        logic [63:0] a  = {$urandom, $urandom};
        if ($urandom % 4 != 0) a = (md == 0) ? (a & 64'hFFFF) : 64'($signed(a[47:0]));
        arm("RND", a, ($urandom % 6 == 0) ? $urandom | 1 : 0, $urandom,
            ($urandom % 4 == 0) ? 2'($urandom) : 2'd0, md, ($urandom % 8) != 0);
      end else if (op < 7) begin
        logic [63:0] sa = ($urandom % 2) ? (m_base | 64'($urandom % 64)) : {$urandom, $urandom};
        step("RND", ($urandom % 8) == 0, sa, 0, 0, 0, 1, 1, 1, sa,
             ($urandom % 2) ? WB : 3'($urandom), 0);
      end else begin
        step("RND", 0, '0, '0, '0, 0, 0, 1, 0, '0, 3'd0, 1);
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule